// File: doc/BRIEF.md
# Protected System Clock Divider Controller

This block generates the clocks of a small microcontroller core from its main oscillator clock. Two 8-bit control registers set it up. A CPU clock enable is divided down from the main clock by 1, 2, 4, 8 or 16. Three peripheral enables run at the full rate, one eighth of it and one thirty-second of it. One divided clock can be driven as a square wave onto a pin that is otherwise a plain port. All clocks run in the main clock domain as single-cycle enable pulses, so downstream logic stays on one clock net.

Software changes either register only while an external protect bit (`unlock_i`) is high. A wait input can silence the peripheral enables. Setting the stop bit halts everything and forces the divider into its slowest safe ratio. An external wake input resumes operation, and the ratio stays at divide-by-8.

Top module: `sysclk_ctl`

## Requirements
- R1: After reset the registers read 0x48 (reg 0) and 0x20 (reg 1). Reg 0 bit 3 always reads 1. Reg 0 bits 7, 5 and 4 and reg 1 bits 4 to 1 always read 0, whatever is written.
- R2: A write with `wr_en_i` high loads reg 0 (`wr_sel_i`=0) or reg 1 (`wr_sel_i`=1) at the next edge only if `unlock_i` is high. Otherwise both registers keep their values.
- R3: `cpu_ce_o` pulses once every N main-clock cycles. N is 8 when reg 0 bit 6 is 1, whatever reg 1 bits 7:6 hold. Otherwise reg 1 bits 7:6 give N: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 16.
- R4: A new ratio is adopted only in the cycle after a `cpu_ce_o` pulse. The period in progress always completes at the old ratio.
- R5: A 5-bit cycle counter starts at 0 after reset or after stop ends. `per1_ce_o` is high every cycle. `per8_ce_o` is high when the counter's low 3 bits are all 1. `per32_ce_o` is high when the counter is 31.
- R6: While `wait_i` is high and reg 0 bit 2 is 1, the three peripheral enables and `pin_clk_o` are 0. With reg 0 bit 2 at 0, `wait_i` has no effect.
- R7: Reg 0 bits 1:0 select the pin function. 10 drives counter bit 2 (period 8) and 11 drives counter bit 4 (period 32) on `pin_clk_o`, with `pin_sel_o`=1. 00 and 01 keep the pin a port, with `pin_sel_o`=0 and `pin_clk_o`=0.
- R8: A permitted write to reg 1 with bit 0 set enters stop mode. At the next edge reg 1 bit 0, reg 1 bit 5 and reg 0 bit 6 become 1. While `stop_o` is high, every clock enable and `pin_clk_o` are 0.
- R9: In stop mode, register writes are ignored. `wake_i` clears reg 1 bit 0 at the next edge, and the divider restarts from zero at divide-by-8. Outside stop mode `wake_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | main clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| wr_en_i | input | 1 | register write strobe |
| wr_sel_i | input | 1 | register select: 0 = reg 0, 1 = reg 1 |
| wr_data_i | input | 8 | write data |
| unlock_i | input | 1 | protect bit, permits writes when high |
| wait_i | input | 1 | core is in wait mode |
| wake_i | input | 1 | external wake-up from stop mode |
| ctl0_o | output | 8 | reg 0 contents |
| ctl1_o | output | 8 | reg 1 contents |
| stop_o | output | 1 | stop mode active |
| cpu_ce_o | output | 1 | CPU clock enable pulse |
| per1_ce_o | output | 1 | full-rate peripheral enable |
| per8_ce_o | output | 1 | divide-by-8 peripheral enable |
| per32_ce_o | output | 1 | divide-by-32 peripheral enable |
| pin_sel_o | output | 1 | pin carries a clock (1) or is a port (0) |
| pin_clk_o | output | 1 | clock level for the pin |

## Verification
The hardest case to reach is a ratio change that lands in the middle of a long divide period. The adopted ratio cannot be seen directly; only the spacing of later CPU pulses shows it. The stimulus first sets divide-by-16, waits a number of cycles that is not a multiple of 16, then selects no division. The bench confirms that the old period runs out before pulses arrive on every cycle. A cycle model in the bench predicts every output each cycle, which also covers entering stop and leaving it through wake.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
   localparam int unsigned REG_W      = 8;
   localparam int unsigned SHIFT_W    = 3;
   localparam int unsigned MAX_SHIFT  = 4;
   localparam int unsigned RST_SHIFT  = 3;

   localparam logic [REG_W-1:0] C0_RST    = 8'h48;
   localparam logic [REG_W-1:0] C1_RST    = 8'h20;
   localparam logic [REG_W-1:0] C0_WMASK  = 8'h47;
   localparam logic [REG_W-1:0] C0_FIXED  = 8'h08;
   localparam logic [REG_W-1:0] C1_WMASK  = 8'hE1;

   localparam int unsigned B_WGATE  = 2;
   localparam int unsigned B_FORCE8 = 6;
   localparam int unsigned B_STOP   = 0;
   localparam int unsigned B_DRIVE  = 5;
   localparam int unsigned B_DIVLO  = 6;

   typedef enum logic [1:0] {
      PIN_PORT  = 2'b00,
      PIN_BAD   = 2'b01,
      PIN_DIV8  = 2'b10,
      PIN_DIV32 = 2'b11
   } pin_mode_e;

   function automatic logic [SHIFT_W-1:0] div_shift(input logic force8,
                                                    input logic [1:0] sel);
      if (force8) return SHIFT_W'(RST_SHIFT);
      case (sel)
         2'b00:   return SHIFT_W'(0);
         2'b01:   return SHIFT_W'(1);
         2'b10:   return SHIFT_W'(2);
         default: return SHIFT_W'(MAX_SHIFT);
      endcase
   endfunction
endpackage

// File: rtl/sysclk_regs.sv
module sysclk_regs
   import sysclk_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic             wr_sel_i,
   input  logic [REG_W-1:0] wr_data_i,
   input  logic             unlock_i,
   input  logic             wake_i,
   output logic [REG_W-1:0] ctl0_o,
   output logic [REG_W-1:0] ctl1_o
);
   logic halted;
   logic wr_ok;

   assign halted = ctl1_o[B_STOP];
   assign wr_ok  = wr_en_i & unlock_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctl0_o <= C0_RST;
         ctl1_o <= C1_RST;
      end else if (halted) begin
         if (wake_i) ctl1_o[B_STOP] <= 1'b0;
      end else if (wr_ok) begin
         if (!wr_sel_i) begin
            ctl0_o <= (wr_data_i & C0_WMASK) | C0_FIXED;
         end else begin
            ctl1_o <= wr_data_i & C1_WMASK;
            if (wr_data_i[B_STOP]) begin
               ctl1_o[B_DRIVE]  <= 1'b1;
               ctl0_o[B_FORCE8] <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sysclk_cpudiv.sv
module sysclk_cpudiv
   import sysclk_pkg::*;
#(
   parameter int unsigned MAX_SH = MAX_SHIFT,
   parameter int unsigned RST_SH = RST_SHIFT,
   parameter int unsigned SH_W   = SHIFT_W
)(
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            halt_i,
   input  logic [SH_W-1:0] req_shift_i,
   output logic            cpu_ce_o
);
   localparam int unsigned CNT_W = (MAX_SH > 0) ? MAX_SH : 1;

   if (RST_SH > MAX_SH) begin : g_bad_rst
      $error("sysclk_cpudiv: reset shift above maximum shift");
   end
   if ((1 << SH_W) <= MAX_SH) begin : g_bad_shw
      $error("sysclk_cpudiv: shift width too narrow");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [SH_W-1:0]  act_q;
   logic [CNT_W-1:0] last;
   logic             term;

   assign last     = CNT_W'((32'd1 << act_q) - 32'd1);
   assign term     = (cnt_q == last);
   assign cpu_ce_o = term & ~halt_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         act_q <= SH_W'(RST_SH);
      end else if (halt_i || term) begin
         cnt_q <= '0;
         act_q <= req_shift_i;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/sysclk_perdiv.sv
module sysclk_perdiv #(
   parameter int unsigned PW      = 5,
   parameter int unsigned MID_TAP = 3
)(
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          halt_i,
   input  logic          gate_i,
   output logic [PW-1:0] cnt_o,
   output logic          ce_full_o,
   output logic          ce_mid_o,
   output logic          ce_top_o
);
   if (MID_TAP == 0 || MID_TAP >= PW) begin : g_bad_tap
      $error("sysclk_perdiv: middle tap must lie inside the counter");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_o <= '0;
      else if (halt_i) cnt_o <= '0;
      else             cnt_o <= cnt_o + PW'(1);
   end

   assign ce_full_o = ~gate_i;
   assign ce_mid_o  = ~gate_i & (&cnt_o[MID_TAP-1:0]);
   assign ce_top_o  = ~gate_i & (&cnt_o);
endmodule

// File: rtl/sysclk_ctl.sv
module sysclk_ctl
   import sysclk_pkg::*;
#(
   parameter int unsigned PER_W   = 5,
   parameter int unsigned PER_MID = 3
)(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic             wr_sel_i,
   input  logic [REG_W-1:0] wr_data_i,
   input  logic             unlock_i,
   input  logic             wait_i,
   input  logic             wake_i,
   output logic [REG_W-1:0] ctl0_o,
   output logic [REG_W-1:0] ctl1_o,
   output logic             stop_o,
   output logic             cpu_ce_o,
   output logic             per1_ce_o,
   output logic             per8_ce_o,
   output logic             per32_ce_o,
   output logic             pin_sel_o,
   output logic             pin_clk_o
);
   localparam int unsigned PIN_LO_BIT = PER_MID - 1;
   localparam int unsigned PIN_HI_BIT = PER_W - 1;

   if (PER_MID < 1 || PER_MID >= PER_W) begin : g_bad_per
      $error("sysclk_ctl: peripheral taps out of range");
   end

   logic [PER_W-1:0]   pcnt;
   logic [SHIFT_W-1:0] req_shift;
   logic               gate;
   pin_mode_e          pin_mode;

   sysclk_regs u_regs (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_sel_i  (wr_sel_i),
      .wr_data_i (wr_data_i),
      .unlock_i  (unlock_i),
      .wake_i    (wake_i),
      .ctl0_o    (ctl0_o),
      .ctl1_o    (ctl1_o)
   );

   assign stop_o    = ctl1_o[B_STOP];
   assign gate      = stop_o | (wait_i & ctl0_o[B_WGATE]);
   assign req_shift = div_shift(ctl0_o[B_FORCE8], ctl1_o[B_DIVLO+1:B_DIVLO]);

   sysclk_cpudiv u_cpudiv (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .halt_i      (stop_o),
      .req_shift_i (req_shift),
      .cpu_ce_o    (cpu_ce_o)
   );

   sysclk_perdiv #(.PW(PER_W), .MID_TAP(PER_MID)) u_perdiv (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .halt_i    (stop_o),
      .gate_i    (gate),
      .cnt_o     (pcnt),
      .ce_full_o (per1_ce_o),
      .ce_mid_o  (per8_ce_o),
      .ce_top_o  (per32_ce_o)
   );

   assign pin_mode  = pin_mode_e'(ctl0_o[1:0]);
   assign pin_sel_o = ctl0_o[1];

   always_comb begin
      unique case (pin_mode)
         PIN_DIV8:  pin_clk_o = pcnt[PIN_LO_BIT] & ~gate;
         PIN_DIV32: pin_clk_o = pcnt[PIN_HI_BIT] & ~gate;
         default:   pin_clk_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/sysclk_ctl_chk.sv
module sysclk_ctl_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       wr_en_i,
   input logic       unlock_i,
   input logic       wait_i,
   input logic       wake_i,
   input logic [7:0] ctl0_o,
   input logic [7:0] ctl1_o,
   input logic       stop_o,
   input logic       cpu_ce_o,
   input logic       per1_ce_o,
   input logic       per8_ce_o,
   input logic       per32_ce_o,
   input logic       pin_clk_o
);
   a_r1_reserved_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((ctl0_o & 8'hB8) == 8'h08) && ((ctl1_o & 8'h1E) == 8'h00));

   a_r2_no_write_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stop_o && !(wr_en_i && unlock_i)) |=> ($stable(ctl0_o) && $stable(ctl1_o)));

   a_r5_top_implies_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      per32_ce_o |-> per8_ce_o);

   a_r6_wait_silences: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wait_i && ctl0_o[2]) |-> (!per1_ce_o && !per8_ce_o && !per32_ce_o && !pin_clk_o));

   a_r7_port_mode_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctl0_o[1] |-> !pin_clk_o);

   a_r8_stop_forces_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(stop_o) |-> (ctl0_o[6] && ctl1_o[5]));

   a_r8_stop_all_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_o |-> (!cpu_ce_o && !per1_ce_o && !pin_clk_o));

   a_r9_stays_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stop_o && !wake_i) |=> stop_o);

   a_r9_wake_keeps_div8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(stop_o) |-> ctl0_o[6]);
endmodule

bind sysclk_ctl sysclk_ctl_chk u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .wr_en_i    (wr_en_i),
   .unlock_i   (unlock_i),
   .wait_i     (wait_i),
   .wake_i     (wake_i),
   .ctl0_o     (ctl0_o),
   .ctl1_o     (ctl1_o),
   .stop_o     (stop_o),
   .cpu_ce_o   (cpu_ce_o),
   .per1_ce_o  (per1_ce_o),
   .per8_ce_o  (per8_ce_o),
   .per32_ce_o (per32_ce_o),
   .pin_clk_o  (pin_clk_o)
);

// File: tb/sim_sysclk_ctl.sv
`timescale 1ns/1ps
module sim_sysclk_ctl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, wr_sel = 1'b0, unlock = 1'b0;
   logic       wait_in = 1'b0, wake = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] ctl0, ctl1;
   logic       stop, cpu_ce, p1, p8, p32, psel, pclk;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sysclk_ctl u0 (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
      .wr_data_i(wr_data), .unlock_i(unlock), .wait_i(wait_in), .wake_i(wake),
      .ctl0_o(ctl0), .ctl1_o(ctl1), .stop_o(stop), .cpu_ce_o(cpu_ce),
      .per1_ce_o(p1), .per8_ce_o(p8), .per32_ce_o(p32),
      .pin_sel_o(psel), .pin_clk_o(pclk)
   );

   typedef struct packed {
      logic [7:0] c0, c1;
      logic st, ce, e1, e8, e32, ps, pc;
   } exp_t;
   exp_t q[$];

   logic [7:0] m0, m1;
   int mcnt, mact, mp;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model: predicts the outputs after each edge, from the requirements
   always @(posedge clk) begin
      logic [7:0] n0, n1;
      logic st, gate;
      int req;
      exp_t e;
      if (!rst_n) begin
         m0 = 8'h48; m1 = 8'h20; mcnt = 0; mact = 3; mp = 0;
      end else begin
         st = m1[0];
         if (m0[6]) req = 3;
         else case (m1[7:6])
            2'b00: req = 0; 2'b01: req = 1; 2'b10: req = 2; default: req = 4;
         endcase
         n0 = m0; n1 = m1;
         if (st) begin
            if (wake) n1[0] = 1'b0;
         end else if (wr_en && unlock) begin
            if (!wr_sel) n0 = (wr_data & 8'h47) | 8'h08;
            else begin
               n1 = wr_data & 8'hE1;
               if (wr_data[0]) begin n1[5] = 1'b1; n0[6] = 1'b1; end
            end
         end
         if (st || mcnt == (1 << mact) - 1) begin mcnt = 0; mact = req; end
         else mcnt++;
         mp = st ? 0 : (mp + 1) % 32;
         m0 = n0; m1 = n1;
      end
      st   = m1[0];
      gate = st | (wait_in & m0[2]);
      e.c0 = m0; e.c1 = m1; e.st = st;
      e.ce  = !st && (mcnt == (1 << mact) - 1);
      e.e1  = !gate;
      e.e8  = !gate && (mp % 8 == 7);
      e.e32 = !gate && (mp == 31);
      e.ps  = m0[1];
      e.pc  = gate ? 1'b0 : (m0[1:0] == 2'b10) ? mp[2] : (m0[1:0] == 2'b11) ? mp[4] : 1'b0;
      q.push_back(e);
   end

   // monitor: compares each cycle's outputs away from the active edge
   always @(negedge clk) begin
      exp_t e;
      if (q.size() > 0 && !done) begin
         e = q.pop_front();
         chk("R2 ctl0", ctl0, e.c0);
         chk("R2 ctl1", ctl1, e.c1);
         chk("R8 stop", stop, e.st);
         chk("R3 cpu_ce", cpu_ce, e.ce);
         chk("R5 per1", p1, e.e1);
         chk("R5 per8", p8, e.e8);
         chk("R5 per32", p32, e.e32);
         chk("R7 pin_sel", psel, e.ps);
         chk("R7 pin_clk", pclk, e.pc);
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic wr(input logic sel, input logic [7:0] d, input logic unl);
      @(negedge clk); #1;
      wr_en = 1'b1; wr_sel = sel; wr_data = d; unlock = unl;
      @(negedge clk); #1;
      wr_en = 1'b0; unlock = 1'b0; wr_data = 8'h00;
   endtask

   initial begin
      int cnt8;
      int gap;
      idle(4);
      chk("R1 reset ctl0", ctl0, 8'h48);
      chk("R1 reset ctl1", ctl1, 8'h20);
      rst_n = 1'b1;
      cnt8 = 0;
      repeat (64) begin @(negedge clk); if (p8) cnt8++; end
      chk("R5 per8 pulses in 64 cycles", cnt8, 8);

      wr(1'b1, 8'hC0, 1'b0);
      chk("R2 locked write ignored", ctl1, 8'h20);
      wr(1'b0, 8'hFF, 1'b1);
      chk("R1 reserved after all-ones", ctl0, 8'h4F);
      idle(70);
      wr(1'b0, 8'h00, 1'b1);
      chk("R1 reserved after all-zeros", ctl0, 8'h08);
      idle(20);
      wr(1'b1, 8'h40, 1'b1); idle(30);
      wr(1'b1, 8'h80, 1'b1); idle(40);
      wr(1'b1, 8'hC0, 1'b1); idle(53);
      // R4: change to no division in the middle of a 16-cycle period
      wr(1'b1, 8'h00, 1'b1);
      gap = 0;
      while (!cpu_ce && gap < 40) begin @(negedge clk); gap++; end
      chk("R4 old period completes", (gap > 0 && gap <= 16), 1);
      @(negedge clk);
      chk("R4 new ratio after pulse", cpu_ce, 1'b1);
      idle(10);
      wr(1'b1, 8'hC0, 1'b1);
      wr(1'b0, 8'h40, 1'b1);
      idle(60);
      chk("R3 override forces div8 field", ctl0[6], 1'b1);

      wr(1'b0, 8'h02, 1'b1); idle(40);
      wr(1'b0, 8'h03, 1'b1); idle(80);
      wr(1'b0, 8'h01, 1'b1); idle(5);
      chk("R7 invalid code keeps port", psel, 1'b0);
      idle(20);

      wr(1'b0, 8'h06, 1'b1);
      wait_in = 1'b1; idle(3);
      chk("R6 wait gates per1", p1, 1'b0);
      idle(20);
      wait_in = 1'b0; idle(10);
      wr(1'b0, 8'h02, 1'b1);
      wait_in = 1'b1; idle(3);
      chk("R6 wait without gate bit", p1, 1'b1);
      idle(20);
      wait_in = 1'b0;

      wake = 1'b1; idle(1); wake = 1'b0;
      chk("R9 wake ignored when running", stop, 1'b0);
      wr(1'b1, 8'h01, 1'b1);
      chk("R8 stop entered", stop, 1'b1);
      chk("R8 reg1 forced", ctl1, 8'h21);
      chk("R8 reg0 div8 forced", ctl0[6], 1'b1);
      idle(10);
      wr(1'b0, 8'h00, 1'b1);
      chk("R9 write ignored in stop", ctl0, 8'h4A);
      idle(10);
      wake = 1'b1; idle(1); wake = 1'b0;
      chk("R9 wake clears stop", stop, 1'b0);
      chk("R9 div8 kept", ctl0[6], 1'b1);
      idle(60);
      wr(1'b0, 8'h03, 1'b1);
      wr(1'b1, 8'h40, 1'b1); idle(40);
      wait_in = 1'b1; wr(1'b0, 8'h07, 1'b1); idle(20); wait_in = 1'b0;
      idle(20);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule